// File: doc/BRIEF.md
# Segment Translation and Protection Unit

This unit turns a two-part logical address, a segment number with an offset, into a flat 32-bit address. It reads a small table held on chip. Each slot in the table gives the segment's start address, its length, and a flag that marks the segment as read-only, such as code, or as writable, such as data or stack. A table-size register gives how many slots are currently in use.

Before the start address and the offset are added, each request passes through four checks. The segment number must be below the table size. The offset must be below the segment length. A write must not target a read-only segment. The sum must not exceed 32 bits. The first check that fails, in that order, sets a distinct fault code, and the address output then reads zero.

The result is registered, so it appears one cycle after the request. Supervisor software loads table slots and the table size through separate write ports. A table write or size write in a given cycle affects only requests that arrive in later cycles.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `out_valid` is 0, `out_fault` is 0 and `out_addr` is 0. The table size is 0, so a first request to any segment faults with code 1.
- R2: A request whose segment number is greater than or equal to the table size gives fault code 1.
- R3: A request whose offset is greater than or equal to the segment length gives fault code 2. A segment of length 0 faults at every offset.
- R4: On any fault (`out_fault` not 0), `out_addr` is 0.
- R5: A write request (`tx_write`=1) to a segment whose read-only flag is set gives fault code 3. Reads of that segment, and writes to segments without the flag, do not give code 3.
- R6: A request that passes every check gives `out_fault`=0 and `out_addr` equal to the start address plus the offset. The start address needs no alignment.
- R7: If the start address plus the offset does not fit in 32 bits, the request gives fault code 4 instead of a wrapped address.
- R8: When several checks fail, the code reported is the first failing check in this order: segment number (1), length (2), protection (3), overflow (4).
- R9: A request accepted on one rising edge shows its result on the next edge. `out_valid` equals the `tx_valid` of the previous cycle.
- R10: A table-slot write or table-size write in the same cycle as a request does not affect that request. It does affect the request in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_valid | input | 1 | Request present |
| tx_seg | input | SEG_W | Segment number |
| tx_off | input | 32 | Offset within segment |
| tx_write | input | 1 | 1 = write access, 0 = read/fetch |
| tbl_we | input | 1 | Table slot write strobe |
| tbl_idx | input | SEG_W | Slot being written |
| tbl_base | input | 32 | Start address for the slot |
| tbl_len | input | 32 | Segment length for the slot |
| tbl_ro | input | 1 | Read-only flag for the slot |
| size_we | input | 1 | Table-size write strobe |
| size_val | input | SEG_W+1 | New table size (0 to 2^SEG_W) |
| out_valid | output | 1 | Result present |
| out_addr | output | 32 | Translated address, 0 on fault |
| out_fault | output | 3 | 0 none, 1 segment number, 2 length, 3 protection, 4 overflow |

## Verification
Priority between faults is the hardest case to reach. It needs a single request that would fail more than one check, and for protection against overflow it needs a read-only segment placed near the top of the address space. The bench loads such a segment and then issues a write and a read at the same offset. The write must report protection and the read must report overflow. A second hard case is a write landing in the same cycle as a request. The bench drives both on the same edge and compares the result against the old contents, then repeats the request and compares against the new contents.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int ADDR_W = 32;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [2:0] {
        FLT_NONE  = 3'd0,
        FLT_SEGNO = 3'd1,
        FLT_LEN   = 3'd2,
        FLT_PROT  = 3'd3,
        FLT_WRAP  = 3'd4
    } fault_e;

    typedef struct packed {
        addr_t base;
        addr_t len;
        logic  ro;
    } seg_slot_t;

    typedef struct packed {
        fault_e fault;
        addr_t  addr;
    } xlate_res_t;

    function automatic logic [ADDR_W:0] wide_sum(input addr_t a, input addr_t b);
        return {1'b0, a} + {1'b0, b};
    endfunction

endpackage

// File: rtl/seg_table.sv
module seg_table
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SEG_W-1:0] widx,
    input  seg_slot_t        wdata,
    input  logic [SEG_W-1:0] ridx,
    output seg_slot_t        rdata
);
    localparam int NSEG = 1 << SEG_W;

    seg_slot_t slots [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[g] <= '0;
            end else if (we && widx == SEG_W'(g)) begin
                slots[g] <= wdata;
            end
        end
    end

    assign rdata = slots[ridx];

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W = 3
) (
    input  logic [SEG_W-1:0] seg,
    input  addr_t            off,
    input  logic             is_write,
    input  logic [SEG_W:0]   tbl_size,
    input  seg_slot_t        slot,
    output xlate_res_t       res
);
    logic [ADDR_W:0] sum;

    always_comb begin
        sum       = wide_sum(slot.base, off);
        res.addr  = '0;
        res.fault = FLT_NONE;
        if ({1'b0, seg} >= tbl_size) begin
            res.fault = FLT_SEGNO;
        end else if (off >= slot.len) begin
            res.fault = FLT_LEN;
        end else if (is_write && slot.ro) begin
            res.fault = FLT_PROT;
        end else if (sum[ADDR_W]) begin
            res.fault = FLT_WRAP;
        end else begin
            res.addr = sum[ADDR_W-1:0];
        end
    end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_valid,
    input  logic [SEG_W-1:0] tx_seg,
    input  logic [31:0]      tx_off,
    input  logic             tx_write,
    input  logic             tbl_we,
    input  logic [SEG_W-1:0] tbl_idx,
    input  logic [31:0]      tbl_base,
    input  logic [31:0]      tbl_len,
    input  logic             tbl_ro,
    input  logic             size_we,
    input  logic [SEG_W:0]   size_val,
    output logic             out_valid,
    output logic [31:0]      out_addr,
    output logic [2:0]       out_fault
);
    logic [SEG_W:0] size_q;
    seg_slot_t      wslot;
    seg_slot_t      rslot;
    xlate_res_t     res_d;
    xlate_res_t     res_q;
    logic           vld_q;

    assign wslot = '{base: tbl_base, len: tbl_len, ro: tbl_ro};

    always_ff @(posedge clk) begin
        if (rst) begin
            size_q <= '0;
        end else if (size_we) begin
            size_q <= size_val;
        end
    end

    seg_table #(.SEG_W(SEG_W)) u_table (
        .clk   (clk),
        .rst   (rst),
        .we    (tbl_we),
        .widx  (tbl_idx),
        .wdata (wslot),
        .ridx  (tx_seg),
        .rdata (rslot)
    );

    seg_check #(.SEG_W(SEG_W)) u_check (
        .seg      (tx_seg),
        .off      (tx_off),
        .is_write (tx_write),
        .tbl_size (size_q),
        .slot     (rslot),
        .res      (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '{fault: FLT_NONE, addr: '0};
        end else begin
            vld_q <= tx_valid;
            if (tx_valid) begin
                res_q <= res_d;
            end
        end
    end

    assign out_valid = vld_q;
    assign out_addr  = res_q.addr;
    assign out_fault = res_q.fault;

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
    parameter int SEG_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             tx_valid,
    input logic [SEG_W-1:0] tx_seg,
    input logic             tx_write,
    input logic [SEG_W:0]   size_q,
    input logic             out_valid,
    input logic [31:0]      out_addr,
    input logic [2:0]       out_fault
);
    p_valid_follow_r9: assert property (@(posedge clk) disable iff (rst)
        tx_valid |=> out_valid);

    p_idle_follow_r9: assert property (@(posedge clk) disable iff (rst)
        !tx_valid |=> !out_valid);

    p_fault_zero_addr_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_fault != 3'd0) |-> out_addr == 32'd0);

    p_bad_segno_r2: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && {1'b0, tx_seg} >= size_q) |=> out_fault == 3'd1);

    p_read_no_prot_r5: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_write) |=> out_fault != 3'd3);

    p_code_range_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_fault <= 3'd4);

endmodule

bind seg_xlate seg_xlate_chk #(.SEG_W(SEG_W)) u_seg_xlate_chk (
    .clk       (clk),
    .rst       (rst),
    .tx_valid  (tx_valid),
    .tx_seg    (tx_seg),
    .tx_write  (tx_write),
    .size_q    (size_q),
    .out_valid (out_valid),
    .out_addr  (out_addr),
    .out_fault (out_fault)
);

// File: tb/test_seg_xlate.sv
module test_seg_xlate;
    localparam int SEG_W = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             tx_valid = 1'b0;
    logic [SEG_W-1:0] tx_seg = '0;
    logic [31:0]      tx_off = '0;
    logic             tx_write = 1'b0;
    logic             tbl_we = 1'b0;
    logic [SEG_W-1:0] tbl_idx = '0;
    logic [31:0]      tbl_base = '0;
    logic [31:0]      tbl_len = '0;
    logic             tbl_ro = 1'b0;
    logic             size_we = 1'b0;
    logic [SEG_W:0]   size_val = '0;
    logic             out_valid;
    logic [31:0]      out_addr;
    logic [2:0]       out_fault;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    seg_xlate #(.SEG_W(SEG_W)) i_seg_xlate (
        .clk, .rst, .tx_valid, .tx_seg, .tx_off, .tx_write,
        .tbl_we, .tbl_idx, .tbl_base, .tbl_len, .tbl_ro,
        .size_we, .size_val, .out_valid, .out_addr, .out_fault
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic load_slot(input int idx, input logic [31:0] b, input logic [31:0] l, input logic ro);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = SEG_W'(idx); tbl_base = b; tbl_len = l; tbl_ro = ro;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic set_size(input int n);
        @(negedge clk);
        size_we = 1'b1; size_val = (SEG_W+1)'(n);
        @(negedge clk);
        size_we = 1'b0;
    endtask

    task automatic xlate(input string tag, input int seg, input logic [31:0] off,
                         input logic wr, input logic [2:0] efault, input logic [31:0] eaddr);
        @(negedge clk);
        tx_valid = 1'b1; tx_seg = SEG_W'(seg); tx_off = off; tx_write = wr;
        @(negedge clk);
        tx_valid = 1'b0;
        check({tag, " R9 valid"}, {31'd0, out_valid}, 32'd1);
        check({tag, " fault"}, {29'd0, out_fault}, {29'd0, efault});
        check({tag, (efault != 3'd0) ? " R4 addr" : " addr"}, out_addr, eaddr);
    endtask

    task automatic t_reset();
        check("R1 valid", {31'd0, out_valid}, 32'd0);
        check("R1 fault", {29'd0, out_fault}, 32'd0);
        check("R1 addr", out_addr, 32'd0);
        xlate("R1 size zero", 0, 32'd0, 1'b0, 3'd1, 32'd0);
    endtask

    task automatic t_setup();
        load_slot(0, 32'h0000_1000, 32'h100, 1'b0);
        load_slot(1, 32'h0000_0003, 32'h10, 1'b1);
        load_slot(2, 32'hFFFF_FFF0, 32'h100, 1'b0);
        load_slot(3, 32'h0000_5000, 32'h0, 1'b0);
        load_slot(4, 32'hFFFF_FF00, 32'h200, 1'b1);
        set_size(5);
    endtask

    task automatic t_translate();
        xlate("R6 seg0", 0, 32'h20, 1'b0, 3'd0, 32'h0000_1020);
        xlate("R6 unaligned", 1, 32'h5, 1'b0, 3'd0, 32'h0000_0008);
        xlate("R6 last byte", 0, 32'hFF, 1'b0, 3'd0, 32'h0000_10FF);
    endtask

    task automatic t_limit();
        xlate("R3 at len", 0, 32'h100, 1'b0, 3'd2, 32'd0);
        xlate("R3 zero len", 3, 32'h0, 1'b0, 3'd2, 32'd0);
    endtask

    task automatic t_prot();
        xlate("R5 write ro", 1, 32'h2, 1'b1, 3'd3, 32'd0);
        xlate("R5 write rw", 0, 32'h2, 1'b1, 3'd0, 32'h0000_1002);
    endtask

    task automatic t_wrap();
        xlate("R7 carry", 2, 32'h10, 1'b0, 3'd4, 32'd0);
        xlate("R7 top addr", 2, 32'hF, 1'b0, 3'd0, 32'hFFFF_FFFF);
    endtask

    task automatic t_segno();
        xlate("R2 seg5", 5, 32'h0, 1'b0, 3'd1, 32'd0);
        xlate("R2 seg7", 7, 32'h0, 1'b0, 3'd1, 32'd0);
    endtask

    task automatic t_priority();
        xlate("R8 segno over len", 6, 32'hFFFF_FFFF, 1'b1, 3'd1, 32'd0);
        xlate("R8 len over prot", 1, 32'h10, 1'b1, 3'd2, 32'd0);
        xlate("R8 prot over wrap", 4, 32'h100, 1'b1, 3'd3, 32'd0);
        xlate("R8 wrap on read", 4, 32'h100, 1'b0, 3'd4, 32'd0);
    endtask

    task automatic t_idle();
        xlate("R9 one shot", 0, 32'h1, 1'b0, 3'd0, 32'h0000_1001);
        @(negedge clk);
        check("R9 idle", {31'd0, out_valid}, 32'd0);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = '0; tbl_base = 32'h0000_2000; tbl_len = 32'h100; tbl_ro = 1'b0;
        tx_valid = 1'b1; tx_seg = '0; tx_off = 32'h4; tx_write = 1'b0;
        @(negedge clk);
        tbl_we = 1'b0; tx_valid = 1'b0;
        check("R10 old slot", out_addr, 32'h0000_1004);
        xlate("R10 new slot", 0, 32'h4, 1'b0, 3'd0, 32'h0000_2004);
        @(negedge clk);
        size_we = 1'b1; size_val = 4'd8;
        tx_valid = 1'b1; tx_seg = 3'd6; tx_off = 32'h0; tx_write = 1'b0;
        @(negedge clk);
        size_we = 1'b0; tx_valid = 1'b0;
        check("R10 old size", {29'd0, out_fault}, 32'd1);
        xlate("R10 new size", 6, 32'h0, 1'b0, 3'd2, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_setup();
        t_translate();
        t_limit();
        t_prot();
        t_wrap();
        t_segno();
        t_priority();
        t_idle();
        t_same_cycle();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule